// File: doc/BRIEF.md
# Clock Position Capture Window

This block records where the rising edges of a reference clock fall relative to the first rising edge of an external request input. Once armed by a clear pulse, it waits for a request edge, then samples the reference clock level on 32 successive cycles of a fast sampling clock. Each cycle stands in for one delay tap. The samples land in a 32-bit snapshot, starting at bit 0 and moving up to bit 31.

The snapshot is read as two 16-bit halves. Its lowest and highest bits always read as 1, which marks the uncertainty at both ends of the window. A combinational locator reports the first clock edge, where an edge is a pair of adjacent set bits found when scanning upward from bit 1. Software uses the snapshot to choose a delay setting for the request path. That choice is made outside this block.

Control is a small state machine with the states IDLE, CLEAR, ARMED, FILL and DONE. Its transitions are:
- Reset enters IDLE.
- Any state moves to CLEAR while `arm_clr` is high.
- CLEAR moves to ARMED when `arm_clr` falls.
- ARMED moves to FILL on a synchronized request rising edge while the window is enabled.
- FILL moves to DONE after the 32nd sample.
- IDLE and DONE hold until the next clear.

Top module: `clkpos_capture`

## Requirements
- R1: After reset the raw snapshot is empty, so `snap_lo` reads 16'h0001, `snap_hi` reads 16'h8000 and `cap_done` is 0.
- R2: Snapshot bit 0 (`snap_lo[0]`) and bit 31 (`snap_hi[15]`) always read as 1, whatever was sampled.
- R3: The request input passes a two-flop synchronizer. The level of `ref_in` present before the fourth rising `clk` edge after `req_in` rises is stored as sample 0. Sample i comes from the (4+i)th edge and is stored at snapshot bit i, for 32 consecutive cycles.
- R4: No capture takes place until `arm_clr` has been driven high and then low after reset. While `arm_clr` is high, the snapshot empties and `cap_done` is 0 from the next cycle.
- R5: After a clear, only the first request rising edge triggers a capture. Later request edges leave the snapshot unchanged until the next clear.
- R6: `cap_done` rises in the cycle after sample 31 is stored. It then stays high, with the snapshot held, until `arm_clr` goes high.
- R7: A request edge triggers a capture only when `cap_en` is 1 and at least one of `sync_en` or `sub_en` is 1. Otherwise the edge is ignored and the block stays armed.
- R8: `snap_hi` carries snapshot bits 31:16 and `snap_lo` carries bits 15:0.
- R9: `edge_valid` is 1 when some i with 1 <= i <= 30 has snapshot bits i and i+1 both set, and `edge_idx` is then the lowest such i. When no such pair exists, `edge_valid` is 0 and `edge_idx` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast sampling clock, one cycle per delay tap |
| rst_n | input | 1 | Asynchronous active-low reset |
| arm_clr | input | 1 | Clear control; a high-then-low pulse arms the window |
| cap_en | input | 1 | Capture enable |
| sync_en | input | 1 | Synchronization path enable |
| sub_en | input | 1 | Reference subsystem enable |
| req_in | input | 1 | Asynchronous request input |
| ref_in | input | 1 | Level of the reference clock being sampled |
| snap_lo | output | 16 | Snapshot bits 15:0 |
| snap_hi | output | 16 | Snapshot bits 31:16 |
| cap_done | output | 1 | All 32 samples stored since the last clear |
| edge_idx | output | 5 | Index of the first interior set-bit pair |
| edge_valid | output | 1 | An interior pair was found |

## Verification
The assertions assume that `arm_clr` is driven cleanly on the sampling clock and that `req_in` stays low for at least two cycles between rising edges, so that the synchronizer sees every transition. The bench changes every input only at falling clock edges. It releases each clear pulse before raising the request, and it returns `req_in` low with idle cycles in between. The expected snapshot is built from the reference pattern that the bench drives on the documented sample cycles.

// File: rtl/clkpos_pkg.sv
package clkpos_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_CLEAR = 3'd1,
        ST_ARMED = 3'd2,
        ST_FILL  = 3'd3,
        ST_DONE  = 3'd4
    } cap_state_t;

endpackage

// File: rtl/clkpos_req_sync.sv
module clkpos_req_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise_pulse
);

    logic [STAGES-1:0] chain_q;
    logic              prev_q;

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[0] <= 1'b0;
                    else        chain_q[0] <= async_in;
                end
            end else begin : g_rest
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[g] <= 1'b0;
                    else        chain_q[g] <= chain_q[g-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= chain_q[STAGES-1];
    end

    assign rise_pulse = chain_q[STAGES-1] & ~prev_q;

endmodule

// File: rtl/clkpos_fsm.sv
module clkpos_fsm
    import clkpos_pkg::*;
#(
    parameter int SNAP_W = 32,
    localparam int CNT_W = $clog2(SNAP_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              arm_clr,
    input  logic              win_en,
    input  logic              req_rise,
    input  logic              ref_in,
    output logic [SNAP_W-1:0] snap_raw,
    output logic              done
);

    localparam logic [CNT_W-1:0] LAST_TAP = CNT_W'(SNAP_W - 1);

    cap_state_t       state_q, state_d;
    logic [CNT_W-1:0] tap_q;

    always_comb begin
        state_d = state_q;
        if (arm_clr) begin
            state_d = ST_CLEAR;
        end else begin
            unique case (state_q)
                ST_IDLE:  state_d = ST_IDLE;
                ST_CLEAR: state_d = ST_ARMED;
                ST_ARMED: if (req_rise && win_en) state_d = ST_FILL;
                ST_FILL:  if (tap_q == LAST_TAP) state_d = ST_DONE;
                ST_DONE:  state_d = ST_DONE;
                default:  state_d = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            snap_raw <= '0;
            tap_q    <= '0;
            done     <= 1'b0;
        end else if (arm_clr) begin
            snap_raw <= '0;
            tap_q    <= '0;
            done     <= 1'b0;
        end else if (state_q == ST_FILL) begin
            snap_raw[tap_q] <= ref_in;
            tap_q           <= tap_q + 1'b1;
            if (tap_q == LAST_TAP) done <= 1'b1;
        end
    end

endmodule

// File: rtl/clkpos_edge_find.sv
module clkpos_edge_find #(
    parameter int SNAP_W = 32,
    localparam int IDX_W = $clog2(SNAP_W)
) (
    input  logic [SNAP_W-1:0] snap,
    output logic [IDX_W-1:0]  idx,
    output logic              found
);

    always_comb begin
        idx   = '0;
        found = 1'b0;
        for (int i = SNAP_W - 2; i >= 1; i--) begin
            if (snap[i] && snap[i+1]) begin
                idx   = IDX_W'(i);
                found = 1'b1;
            end
        end
    end

endmodule

// File: rtl/clkpos_capture.sv
module clkpos_capture #(
    parameter int SNAP_W      = 32,
    parameter int SYNC_STAGES = 2,
    localparam int HALF_W     = SNAP_W / 2,
    localparam int IDX_W      = $clog2(SNAP_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              arm_clr,
    input  logic              cap_en,
    input  logic              sync_en,
    input  logic              sub_en,
    input  logic              req_in,
    input  logic              ref_in,
    output logic [HALF_W-1:0] snap_lo,
    output logic [HALF_W-1:0] snap_hi,
    output logic              cap_done,
    output logic [IDX_W-1:0]  edge_idx,
    output logic              edge_valid
);

    logic              req_rise;
    logic              win_en;
    logic [SNAP_W-1:0] snap_raw;
    logic [SNAP_W-1:0] snap_full;

    assign win_en = cap_en & (sync_en | sub_en);

    clkpos_req_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .async_in   (req_in),
        .rise_pulse (req_rise)
    );

    clkpos_fsm #(.SNAP_W(SNAP_W)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .arm_clr  (arm_clr),
        .win_en   (win_en),
        .req_rise (req_rise),
        .ref_in   (ref_in),
        .snap_raw (snap_raw),
        .done     (cap_done)
    );

    always_comb begin
        snap_full           = snap_raw;
        snap_full[0]        = 1'b1;
        snap_full[SNAP_W-1] = 1'b1;
    end

    assign snap_lo = snap_full[HALF_W-1:0];
    assign snap_hi = snap_full[SNAP_W-1:HALF_W];

    clkpos_edge_find #(.SNAP_W(SNAP_W)) u_find (
        .snap  (snap_full),
        .idx   (edge_idx),
        .found (edge_valid)
    );

endmodule

// File: rtl/clkpos_capture_chk.sv
module clkpos_capture_chk #(
    parameter int HALF_W = 16,
    parameter int IDX_W  = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              arm_clr,
    input logic [HALF_W-1:0] snap_lo,
    input logic [HALF_W-1:0] snap_hi,
    input logic              cap_done,
    input logic [IDX_W-1:0]  edge_idx,
    input logic              edge_valid
);

    logic [2*HALF_W-1:0] whole;
    assign whole = {snap_hi, snap_lo};

    // R2
    a_r2_boundary_set: assert property (@(posedge clk) disable iff (!rst_n)
        snap_lo[0] && snap_hi[HALF_W-1]);

    // R4
    a_r4_clear_drops_done: assert property (@(posedge clk) disable iff (!rst_n)
        arm_clr |=> !cap_done);

    // R6
    a_r6_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        cap_done && !arm_clr |=> cap_done);

    // R5
    a_r5_snap_held: assert property (@(posedge clk) disable iff (!rst_n)
        cap_done && !arm_clr |=> $stable(whole));

    // R9
    a_r9_pair_real: assert property (@(posedge clk) disable iff (!rst_n)
        edge_valid |-> (edge_idx != '0) && whole[edge_idx] && whole[edge_idx + 1'b1]);

    // R9
    a_r9_idle_index: assert property (@(posedge clk) disable iff (!rst_n)
        !edge_valid |-> edge_idx == '0);

endmodule

bind clkpos_capture clkpos_capture_chk #(.HALF_W(HALF_W), .IDX_W(IDX_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .arm_clr    (arm_clr),
    .snap_lo    (snap_lo),
    .snap_hi    (snap_hi),
    .cap_done   (cap_done),
    .edge_idx   (edge_idx),
    .edge_valid (edge_valid)
);

// File: tb/clkpos_capture_bench.sv
module clkpos_capture_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        arm_clr = 1'b0;
    logic        cap_en = 1'b1;
    logic        sync_en = 1'b0;
    logic        sub_en = 1'b1;
    logic        req_in = 1'b0;
    logic        ref_in = 1'b0;
    logic [15:0] snap_lo, snap_hi;
    logic        cap_done;
    logic [4:0]  edge_idx;
    logic        edge_valid;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    clkpos_capture u_clkpos_capture (
        .clk(clk), .rst_n(rst_n), .arm_clr(arm_clr), .cap_en(cap_en),
        .sync_en(sync_en), .sub_en(sub_en), .req_in(req_in), .ref_in(ref_in),
        .snap_lo(snap_lo), .snap_hi(snap_hi), .cap_done(cap_done),
        .edge_idx(edge_idx), .edge_valid(edge_valid)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] forced(input logic [31:0] p);
        return p | 32'h8000_0001;
    endfunction

    task automatic check_edge(input logic [31:0] s, input string tag);
        logic [4:0] ei = 5'd0;
        logic       ev = 1'b0;
        for (int i = 1; i <= 30; i++) begin
            if (!ev && s[i] && s[i+1]) begin
                ev = 1'b1;
                ei = 5'(i);
            end
        end
        check(edge_valid == ev && edge_idx == ei, tag, {26'd0, edge_valid, edge_idx}, {26'd0, ev, ei});
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic clear_pulse;
        @(negedge clk) arm_clr = 1'b1;
        @(negedge clk) arm_clr = 1'b0;
        @(negedge clk);
    endtask

    // Raise req_in, then drive pattern bit i so that it is sampled on the (4+i)th edge (R3).
    task automatic run_request(input logic [31:0] pat);
        req_in = 1'b1;
        for (int s = 1; s <= 34; s++) begin
            @(negedge clk);
            if (s >= 3) ref_in = pat[s-3];
        end
        @(negedge clk);
        req_in = 1'b0;
        ref_in = 1'b0;
    endtask

    task automatic t_reset;
        check(snap_lo == 16'h0001, "R1 snap_lo after reset", {16'd0, snap_lo}, 32'h0001);
        check(snap_hi == 16'h8000, "R1 snap_hi after reset", {16'd0, snap_hi}, 32'h8000);
        check(cap_done == 1'b0, "R1 done after reset", {31'd0, cap_done}, 32'd0);
        check_edge(32'h8000_0001, "R9 locator after reset");
    endtask

    task automatic t_no_clear;
        run_request(32'hFFFF_FFFF);
        idle(4);
        check(cap_done == 1'b0, "R4 no capture before clear", {31'd0, cap_done}, 32'd0);
        check({snap_hi, snap_lo} == 32'h8000_0001, "R4 snapshot before clear", {snap_hi, snap_lo}, 32'h8000_0001);
    endtask

    task automatic t_capture(input logic [31:0] pat, input string tag);
        clear_pulse();
        run_request(pat);
        check(cap_done == 1'b1, {"R6 done ", tag}, {31'd0, cap_done}, 32'd1);
        check(snap_lo == forced(pat)[15:0], {"R3 R2 low half ", tag}, {16'd0, snap_lo}, {16'd0, forced(pat)[15:0]});
        check(snap_hi == forced(pat)[31:16], {"R8 high half ", tag}, {16'd0, snap_hi}, {16'd0, forced(pat)[31:16]});
        check_edge(forced(pat), {"R9 locator ", tag});
        idle(3);
    endtask

    task automatic t_second_edge;
        logic [31:0] held;
        held = {snap_hi, snap_lo};
        run_request(32'h0F0F_0F0F);
        idle(4);
        check({snap_hi, snap_lo} == held, "R5 second edge ignored", {snap_hi, snap_lo}, held);
        check(cap_done == 1'b1, "R6 done held", {31'd0, cap_done}, 32'd1);
    endtask

    task automatic t_clear_effect;
        @(negedge clk) arm_clr = 1'b1;
        @(negedge clk);
        check(cap_done == 1'b0, "R4 clear drops done", {31'd0, cap_done}, 32'd0);
        check({snap_hi, snap_lo} == 32'h8000_0001, "R4 clear empties", {snap_hi, snap_lo}, 32'h8000_0001);
        arm_clr = 1'b0;
        idle(2);
    endtask

    task automatic t_window;
        clear_pulse();
        cap_en = 1'b0;
        run_request(32'hFFFF_FFFF);
        idle(4);
        check(cap_done == 1'b0 && snap_lo == 16'h0001, "R7 cap_en low ignored", {snap_hi, snap_lo}, 32'h8000_0001);
        cap_en = 1'b1; sub_en = 1'b0; sync_en = 1'b0;
        run_request(32'hFFFF_FFFF);
        idle(4);
        check(cap_done == 1'b0 && snap_lo == 16'h0001, "R7 both enables low ignored", {snap_hi, snap_lo}, 32'h8000_0001);
        sync_en = 1'b1;
        run_request(32'h0000_0C00);
        check(cap_done == 1'b1, "R7 sync_en alone enables", {31'd0, cap_done}, 32'd1);
        check({snap_hi, snap_lo} == forced(32'h0000_0C00), "R7 armed state kept", {snap_hi, snap_lo}, forced(32'h0000_0C00));
        check_edge(forced(32'h0000_0C00), "R9 locator mid pair");
        sync_en = 1'b0; sub_en = 1'b1;
        idle(3);
    endtask

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(2);
        t_reset();
        t_no_clear();
        t_capture(32'h3333_3333, "alternating pairs");
        t_capture(32'h0000_0000, "all low");
        t_capture(32'hFFFF_FFFF, "all high");
        t_capture(32'h4000_0000, "pair at top boundary");
        t_capture(32'h0000_0002, "pair at bottom boundary");
        t_capture(32'h1234_5678, "mixed");
        t_second_edge();
        t_clear_effect();
        t_window();
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog expired actual=%h expected=%h", 32'd1, 32'd0);
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule